// File: doc/BRIEF.md
# Horizontal Sync Regenerator

This block takes a raw horizontal sync that has already been brought into the pixel clock domain. It turns that sync into a clean pulse whose width is programmed, and it keeps the pulse aligned with the pixel word that travels beside it. Only the active edge of each incoming pulse matters. That edge is picked by a programmed input polarity or, in automatic mode, by measuring which level of the line is shorter. The regenerated pulse is delayed through the same register pipeline as the pixel data, so downstream logic sees the sync and the pixel sampled in the same cycle at the same moment. The output polarity is set separately from the input polarity.

Beside the data path, the block gives a clock-generation reference: a one-cycle strobe for each active input edge. It also gives a coast flag derived from vertical sync. While coast is active the strobe is held off, so that sync disturbances in the vertical interval do not reach the clock logic. All settings are plain level inputs that a register file elsewhere drives.

Top module: `hsync_regen`

## Requirements
- R1: With `cfg_in_pol` = 0 a high-to-low change of `hs_in` is the active edge, and with `cfg_in_pol` = 1 a low-to-high change is. The opposite (trailing) change never starts or extends a pulse.
- R2: Each active edge gives an output pulse exactly `cfg_pulse_len` pixel clocks long.
- R3: A `cfg_pulse_len` of 0 produces no output pulse. The reference strobe is not affected.
- R4: An active edge that arrives while a pulse is running restarts the count, so the pulse ends `cfg_pulse_len` clocks after the newest edge.
- R5: `cfg_out_pol` = 1 makes `hs_out` high while the pulse is active and low otherwise. `cfg_out_pol` = 0 inverts both levels.
- R6: An input edge whose pixel clock sample lands on edge E shows on `hs_out` after edge E+PIPE_STAGES. The `pix_in` word sampled at E appears on `pix_out` after the same edge, a latency of PIPE_STAGES+1 clocks.
- R7: With `cfg_auto_pol` = 1, `cfg_in_pol` is ignored. At each rising input change that follows a complete line, the high and low durations of that line are compared, and the shorter level becomes the active level (a tie means active low). The detector starts as active low after reset.
- R8: `ref_edge` is high for exactly one clock, one clock after the clock edge that samples an active edge.
- R9: `coast_out` is high one clock after `vs_in` equals `cfg_coast_pol` while `cfg_coast_en` = 1 (`cfg_coast_pol` = 1 means active high). While coast holds, no `ref_edge` strobe is produced. `hs_out` is not affected.
- R10: During reset `hs_out` sits at the inactive level, and `ref_edge`, `coast_out` and `pix_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_in | input | 1 | Raw horizontal sync, synchronous to clk |
| vs_in | input | 1 | Vertical sync used to derive coast |
| pix_in | input | PIX_W | Pixel word sampled together with hs_in |
| cfg_in_pol | input | 1 | Input active level: 0 low, 1 high |
| cfg_auto_pol | input | 1 | 1 selects measured input polarity |
| cfg_out_pol | input | 1 | Output active level: 0 low, 1 high |
| cfg_pulse_len | input | WIDTH_W | Output pulse length in clocks |
| cfg_coast_en | input | 1 | Enables coast derived from vs_in |
| cfg_coast_pol | input | 1 | Level of vs_in that means coast |
| hs_out | output | 1 | Regenerated sync, aligned with pix_out |
| pix_out | output | PIX_W | Delayed pixel word |
| coast_out | output | 1 | Coast flag for clock generation |
| ref_edge | output | 1 | One-clock strobe per active input edge |

## Verification
A wrong active-edge choice or a bad polarity decision shows in the first line that follows. The pulse starts on the trailing edge, or twice per line, or the pulse count on `hs_out` comes out too long. A counter that is off by one changes the pulse length by one clock. A pipeline that is too short or too long shifts `hs_out` against `pix_out` by whole clocks, and the index written into each pixel word exposes this within PIPE_STAGES+1 clocks of any pulse. A bad coast decode shows at once as a strobe during coast or a missing strobe outside it.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    typedef enum logic {
        ACT_LOW  = 1'b0,
        ACT_HIGH = 1'b1
    } level_e;

    typedef struct packed {
        level_e in_lvl;
        logic   auto_lvl;
        level_e out_lvl;
        logic   coast_on;
        level_e coast_lvl;
    } hsr_cfg_t;

    // true when the change from prev to cur enters the active level
    function automatic logic is_leading(input logic cur, input logic prev, input level_e lvl);
        return (lvl == ACT_HIGH) ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic logic level_match(input logic sig, input level_e lvl);
        return sig == logic'(lvl);
    endfunction

endpackage

// File: rtl/hsr_level_detect.sv
module hsr_level_detect
    import hsr_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   hs_cur,
    input  logic   hs_prev,
    output level_e det_lvl
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] hi_cnt, lo_cnt;
    logic             armed;
    logic             rise_w;

    assign rise_w = hs_cur & ~hs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            armed   <= 1'b0;
            det_lvl <= ACT_LOW;
        end else if (rise_w) begin
            armed  <= 1'b1;
            if (armed)
                det_lvl <= (hi_cnt < lo_cnt) ? ACT_HIGH : ACT_LOW;
            hi_cnt <= CNT_W'(1);
            lo_cnt <= '0;
        end else if (hs_cur) begin
            if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            if (lo_cnt != CNT_MAX) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R7
    det_moves_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(det_lvl) |-> $past(rise_w));

endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen #(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lead,
    input  logic [WID_W-1:0] width,
    output logic             pulse
);
    logic [WID_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (lead)
            remain <= width;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (remain != '0 && !lead) |=> remain == ($past(remain) - WID_W'(1)));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        lead |=> remain == $past(width));

    // R3
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (lead && width == '0) |=> !pulse);

endmodule

// File: rtl/hsr_align_pipe.sv
module hsr_align_pipe #(
    parameter int DATA_W = 25,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_pass
            assign dout = din;
        end else begin : g_regs
            logic [DATA_W-1:0] q [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) q[i] <= '0;
                end else begin
                    q[0] <= din;
                    for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
                end
            end
            assign dout = q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int PIX_W       = 24,
    parameter int WIDTH_W     = 8,
    parameter int LVL_CNT_W   = 12,
    parameter int PIPE_STAGES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hs_in,
    input  logic               vs_in,
    input  logic [PIX_W-1:0]   pix_in,
    input  logic               cfg_in_pol,
    input  logic               cfg_auto_pol,
    input  logic               cfg_out_pol,
    input  logic [WIDTH_W-1:0] cfg_pulse_len,
    input  logic               cfg_coast_en,
    input  logic               cfg_coast_pol,
    output logic               hs_out,
    output logic [PIX_W-1:0]   pix_out,
    output logic               coast_out,
    output logic               ref_edge
);
    localparam int LANE_W = PIX_W + 1;

    hsr_cfg_t cfg;
    assign cfg = '{in_lvl:    level_e'(cfg_in_pol),
                   auto_lvl:  cfg_auto_pol,
                   out_lvl:   level_e'(cfg_out_pol),
                   coast_on:  cfg_coast_en,
                   coast_lvl: level_e'(cfg_coast_pol)};

    logic             hs_prev;
    logic [PIX_W-1:0] pix_d1;
    level_e           det_lvl, eff_lvl;
    logic             lead, pulse, coast_now;
    logic             ref_q, coast_q;
    logic [LANE_W-1:0] lane_in, lane_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_prev <= 1'b0;
            pix_d1  <= '0;
            ref_q   <= 1'b0;
            coast_q <= 1'b0;
        end else begin
            hs_prev <= hs_in;
            pix_d1  <= pix_in;
            ref_q   <= lead & ~coast_now;
            coast_q <= coast_now;
        end
    end

    hsr_level_detect #(.CNT_W(LVL_CNT_W)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .hs_cur  (hs_in),
        .hs_prev (hs_prev),
        .det_lvl (det_lvl)
    );

    assign eff_lvl   = cfg.auto_lvl ? det_lvl : cfg.in_lvl;
    assign lead      = is_leading(hs_in, hs_prev, eff_lvl);
    assign coast_now = cfg.coast_on & level_match(vs_in, cfg.coast_lvl);

    hsr_pulse_gen #(.WID_W(WIDTH_W)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .lead  (lead),
        .width (cfg_pulse_len),
        .pulse (pulse)
    );

    assign lane_in = {pulse, pix_d1};

    hsr_align_pipe #(.DATA_W(LANE_W), .STAGES(PIPE_STAGES)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .din  (lane_in),
        .dout (lane_out)
    );

    assign hs_out    = lane_out[PIX_W] ? logic'(cfg.out_lvl) : ~logic'(cfg.out_lvl);
    assign pix_out   = lane_out[PIX_W-1:0];
    assign coast_out = coast_q;
    assign ref_edge  = ref_q;

    // R9
    no_ref_in_coast_chk: assert property (@(posedge clk) disable iff (rst)
        coast_q |-> !ref_q);

    // R8
    ref_single_chk: assert property (@(posedge clk) disable iff (rst)
        ref_q |=> !ref_q);

endmodule

// File: tb/test_hsync_regen.sv
module test_hsync_regen;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 24;
    localparam int WIDTH_W = 8;
    localparam int PIPE_STAGES = 3;
    localparam int LAT = PIPE_STAGES + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs_in = 1'b1, vs_in = 1'b0;
    logic [PIX_W-1:0] pix_in = '0;
    logic cfg_in_pol = 1'b0, cfg_auto_pol = 1'b0, cfg_out_pol = 1'b1;
    logic [WIDTH_W-1:0] cfg_pulse_len = 8'd5;
    logic cfg_coast_en = 1'b0, cfg_coast_pol = 1'b1;
    logic hs_out, coast_out, ref_edge;
    logic [PIX_W-1:0] pix_out;

    int total = 0, bad = 0, tag = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsync_regen #(.PIX_W(PIX_W), .WIDTH_W(WIDTH_W), .LVL_CNT_W(12),
                  .PIPE_STAGES(PIPE_STAGES)) i_hsync_regen (
        .clk(clk), .rst(rst), .hs_in(hs_in), .vs_in(vs_in), .pix_in(pix_in),
        .cfg_in_pol(cfg_in_pol), .cfg_auto_pol(cfg_auto_pol), .cfg_out_pol(cfg_out_pol),
        .cfg_pulse_len(cfg_pulse_len), .cfg_coast_en(cfg_coast_en),
        .cfg_coast_pol(cfg_coast_pol), .hs_out(hs_out), .pix_out(pix_out),
        .coast_out(coast_out), .ref_edge(ref_edge));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // drives hs_in = pat[j] for j = 0..len-1 and measures the outputs
    task automatic run_pattern(input logic [31:0] pat, input int len,
                               output int first, output int count, output int refs,
                               output int ref_first, output int coast_hi, output int pix_bad);
        tag++;
        first = -1; count = 0; refs = 0; ref_first = -1; coast_hi = 0; pix_bad = 0;
        for (int j = 0; j <= len; j++) begin
            @(negedge clk);
            if (j > 0) begin
                if (hs_out == cfg_out_pol) begin
                    count++;
                    if (first < 0) first = j;
                end
                if (ref_edge) begin
                    refs++;
                    if (ref_first < 0) ref_first = j;
                end
                if (coast_out) coast_hi++;
                if (j >= LAT && pix_out != {8'(tag), 16'(j - LAT)}) pix_bad++;
            end
            if (j < len) begin
                hs_in  = pat[j];
                pix_in = {8'(tag), 16'(j)};
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(hs_out == 1'b0, "R10 hs_out idle", hs_out, 0);
        check(ref_edge == 1'b0 && coast_out == 1'b0, "R10 strobes", ref_edge + coast_out, 0);
        check(pix_out == '0, "R10 pix_out", pix_out, 0);
    endtask

    task automatic t_falling();
        int f, c, r, rf, ch, pb;
        cfg_in_pol = 1'b0; cfg_out_pol = 1'b1; cfg_pulse_len = 8'd5;
        hs_in = 1'b1; idle(12);
        run_pattern(32'hFFFF_FC00, 24, f, c, r, rf, ch, pb);
        check(f == LAT, "R6 first active sample", f, LAT);
        check(c == 5, "R1 R2 width, trailing edge ignored", c, 5);
        check(pb == 0, "R6 pixel alignment", pb, 0);
        check(r == 1 && rf == 1, "R8 ref strobe timing", rf, 1);
    endtask

    task automatic t_rising();
        int f, c, r, rf, ch, pb;
        cfg_in_pol = 1'b1; cfg_pulse_len = 8'd3;
        hs_in = 1'b0; idle(12);
        run_pattern(32'h0000_003F, 24, f, c, r, rf, ch, pb);
        check(f == LAT, "R1 rising edge start", f, LAT);
        check(c == 3, "R2 width three", c, 3);
        check(r == 1, "R8 one ref per line", r, 1);
    endtask

    task automatic t_out_pol();
        int f, c, r, rf, ch, pb;
        cfg_in_pol = 1'b0; cfg_out_pol = 1'b0; cfg_pulse_len = 8'd4;
        hs_in = 1'b1; idle(12);
        check(hs_out == 1'b1, "R5 idle level high", hs_out, 1);
        run_pattern(32'hFFFF_FFF0, 24, f, c, r, rf, ch, pb);
        check(f == LAT && c == 4, "R5 active low pulse", c, 4);
        check(hs_out == 1'b1, "R5 back to idle", hs_out, 1);
        cfg_out_pol = 1'b1;
    endtask

    task automatic t_zero();
        int f, c, r, rf, ch, pb;
        cfg_in_pol = 1'b0; cfg_pulse_len = 8'd0;
        hs_in = 1'b1; idle(12);
        run_pattern(32'hFFFF_FFF0, 24, f, c, r, rf, ch, pb);
        check(c == 0, "R3 zero length", c, 0);
        check(r == 1, "R3 ref still produced", r, 1);
    endtask

    task automatic t_retrigger();
        int f, c, r, rf, ch, pb;
        cfg_in_pol = 1'b0; cfg_pulse_len = 8'd6;
        hs_in = 1'b1; idle(12);
        run_pattern(32'hFFFF_FFC4, 24, f, c, r, rf, ch, pb);
        check(f == LAT, "R4 first", f, LAT);
        check(c == 9, "R4 restarted length", c, 9);
        check(r == 2, "R4 two refs", r, 2);
    endtask

    task automatic t_auto();
        int f, c, r, rf, ch, pb;
        cfg_auto_pol = 1'b1; cfg_in_pol = 1'b0; cfg_pulse_len = 8'd5;
        hs_in = 1'b0; idle(20);
        for (int n = 0; n < 3; n++) run_pattern(32'h0000_000F, 24, f, c, r, rf, ch, pb);
        check(f == LAT && c == 5, "R7 learns active high", f, LAT);
        cfg_in_pol = 1'b1;
        for (int n = 0; n < 3; n++) run_pattern(32'hFFFF_FFF0, 24, f, c, r, rf, ch, pb);
        check(f == LAT && c == 5, "R7 learns active low", f, LAT);
        check(r == 1, "R7 one edge per line", r, 1);
        cfg_auto_pol = 1'b0; cfg_in_pol = 1'b0;
    endtask

    task automatic t_coast();
        int f, c, r, rf, ch, pb;
        cfg_in_pol = 1'b0; cfg_pulse_len = 8'd3;
        cfg_coast_en = 1'b1; cfg_coast_pol = 1'b1; vs_in = 1'b1;
        hs_in = 1'b1; idle(12);
        run_pattern(32'hFFFF_FFF0, 16, f, c, r, rf, ch, pb);
        check(r == 0, "R9 ref masked in coast", r, 0);
        check(ch == 16, "R9 coast high", ch, 16);
        check(c == 3, "R9 hs_out unaffected", c, 3);
        vs_in = 1'b0;
        run_pattern(32'hFFFF_FFF0, 16, f, c, r, rf, ch, pb);
        check(r == 1 && ch == 0, "R9 no coast, vs low", r, 1);
        cfg_coast_pol = 1'b0;
        run_pattern(32'hFFFF_FFF0, 16, f, c, r, rf, ch, pb);
        check(r == 0 && ch == 16, "R9 active low coast", ch, 16);
        cfg_coast_en = 1'b0;
        run_pattern(32'hFFFF_FFF0, 16, f, c, r, rf, ch, pb);
        check(r == 1 && ch == 0, "R9 coast disabled", ch, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(5);
        t_reset();
        rst = 1'b0;
        t_falling();
        t_rising();
        t_out_pol();
        t_zero();
        t_retrigger();
        t_auto();
        t_coast();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule